// File: doc/BRIEF.md
# Daisy-Chain Bus Ownership Requester

This block lets a secondary master borrow an asynchronous, 68000-style system bus from a higher-priority master. Its local client raises a request. The block then pulls the shared request line low and waits, for as long as needed, for the chained grant to arrive from upstream. It also waits until the previous owner has let go of the address strobe and the shared acknowledge line. Only then does it pull acknowledge low and hand ownership to the client. When the client signals completion, the block releases acknowledge and the bus returns to its previous owner.

When the block is neither requesting nor owning the bus, the upstream grant passes straight through to the downstream grant output. Lower-priority masters further down the chain can then be served.

Straight after reset, before any transfer is allowed, the block holds the system reset line low for a fixed number of clocks. This gives the same effect as a processor reset instruction.

All shared lines are open-drain. The block only outputs pull-low enables (`*_pull`, 1 = pull low, 0 = release) and senses the line levels through two-flop synchronizers.

The controller has five states:

- `ST_BOOT`: reset pulse running.
- `ST_IDLE`: grant passed through.
- `ST_REQUEST`: request pulled low, waiting for the grant.
- `ST_WAIT_FREE`: grant seen, waiting for the strobe and acknowledge to be released.
- `ST_OWN`: acknowledge pulled low, client owns the bus.

It has these transitions:

- `boot_done`: `ST_BOOT` to `ST_IDLE`.
- `client_ask`: `ST_IDLE` to `ST_REQUEST`.
- `grant_seen`: `ST_REQUEST` to `ST_WAIT_FREE`.
- `grant_lost`: `ST_WAIT_FREE` to `ST_REQUEST`.
- `bus_free`: `ST_WAIT_FREE` to `ST_OWN`.
- `client_fin`: `ST_OWN` to `ST_IDLE`.

Top module: `chain_bus_requester`

## Requirements
- R1: After reset is released, `sysrst_pull` stays 1 for exactly RESET_CYCLES (default 512) consecutive clock samples. It then drops to 0 and stays 0 until the next reset.
- R2: While `sysrst_pull` is 1, `client_req` is ignored: `req_pull` and `ack_pull` stay 0. A request that is still held when the pulse ends causes `req_pull` to rise on the second clock edge after the first edge at which `sysrst_pull` reads 0.
- R3: Whenever `req_pull` and `ack_pull` are both 0, `grant_out_n` equals `grant_in_n` combinationally.
- R4: Whenever `req_pull` or `ack_pull` is 1, `grant_out_n` is 1 (inactive).
- R5: In the idle state, a 1 on `client_req` at a clock edge makes `req_pull` 1 right after that edge.
- R6: `ack_pull` rises on the 4th clock edge after `grant_in_n` falls, provided `as_line_n` and `ack_line_n` are already high. The grant is seen through 2 synchronizer flops plus one state step.
- R7: While `grant_in_n` stays high, `req_pull` stays 1 and `ack_pull` stays 0 for any number of cycles.
- R8: `ack_pull` is not asserted while the synchronized `as_line_n` or `ack_line_n` is low. After the last of them goes high, `ack_pull` rises on the 3rd edge, but never earlier than the limit of R6.
- R9: `req_pull` and `ack_pull` are never 1 together; `req_pull` falls at the same edge at which `ack_pull` rises.
- R10: `client_grant` is 1 exactly while `ack_pull` is 1.
- R11: A 1 on `client_done` during ownership makes `ack_pull` and `client_grant` 0 right after the next clock edge. Pass-through (R3) then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| client_req | input | 1 | Local client asks for the bus |
| client_done | input | 1 | Local client has finished with the bus |
| client_grant | output | 1 | Client owns the bus |
| grant_in_n | input | 1 | Chained grant from upstream, active low |
| grant_out_n | output | 1 | Chained grant to downstream, active low |
| as_line_n | input | 1 | Sensed level of the shared address strobe |
| ack_line_n | input | 1 | Sensed level of the shared grant-acknowledge line |
| req_pull | output | 1 | Pull the shared request line low |
| ack_pull | output | 1 | Pull the shared grant-acknowledge line low |
| sysrst_pull | output | 1 | Pull the system reset line low |

## Verification
The end of the boot reset pulse and a pending client request fall in the same cycle. The bench holds `client_req` high through the whole pulse and checks two things: nothing is requested while the pulse runs, and `req_pull` appears exactly two edges after the pulse ends, neither lost nor early. A sweep also overlaps the arrival of the grant with a previous owner that still holds the address strobe for 0 to 3 cycles. For each case the bench computes the acknowledge edge as the later of the grant path and the strobe path and checks it cycle by cycle. Completion is driven in the same cycle as the upstream grant is withdrawn. The bench then checks that acknowledge is released and that pass-through resumes at once.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_REQUEST,
        ST_WAIT_FREE,
        ST_OWN
    } arb_state_t;
endpackage

// File: rtl/line_sync.sv
// Multi-bit, multi-stage level synchronizer for sensed bus lines.
module line_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/boot_reset_timer.sv
// Holds the system reset pull active for RESET_CYCLES samples after reset.
module boot_reset_timer #(
    parameter int RESET_CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CW = $clog2(RESET_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/arb_fsm.sv
// Ownership sequencer: request, wait for grant, wait for bus free, own, release.
module arb_fsm
    import chain_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_busy,
    input  logic client_req,
    input  logic client_done,
    input  logic grant_s_n,
    input  logic as_s_n,
    input  logic ack_s_n,
    output logic req_pull,
    output logic ack_pull,
    output logic pass_en
);
    arb_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:      if (!boot_busy)           nxt = ST_IDLE;       // boot_done
            ST_IDLE:      if (client_req)           nxt = ST_REQUEST;    // client_ask
            ST_REQUEST:   if (!grant_s_n)           nxt = ST_WAIT_FREE;  // grant_seen
            ST_WAIT_FREE: begin
                if (grant_s_n)                      nxt = ST_REQUEST;    // grant_lost
                else if (as_s_n && ack_s_n)         nxt = ST_OWN;        // bus_free
            end
            ST_OWN:       if (client_done)          nxt = ST_IDLE;       // client_fin
            default:                                nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_pull = 1'b0;
        ack_pull = 1'b0;
        pass_en  = 1'b0;
        unique case (state)
            ST_BOOT, ST_IDLE:         pass_en  = 1'b1;
            ST_REQUEST, ST_WAIT_FREE: req_pull = 1'b1;
            ST_OWN:                   ack_pull = 1'b1;
            default:                  pass_en  = 1'b1;
        endcase
    end
endmodule

// File: rtl/chain_bus_requester.sv
// Secondary-master requester on a daisy-chained grant bus.
module chain_bus_requester #(
    parameter int RESET_CYCLES = 512,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic client_req,
    input  logic client_done,
    output logic client_grant,
    input  logic grant_in_n,
    output logic grant_out_n,
    input  logic as_line_n,
    input  logic ack_line_n,
    output logic req_pull,
    output logic ack_pull,
    output logic sysrst_pull
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw_lines, sync_lines;
    logic              boot_busy;
    logic              pass_en;

    assign raw_lines = {grant_in_n, as_line_n, ack_line_n};

    line_sync #(
        .WIDTH  (NLINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NLINES{1'b1}})
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_lines),
        .q    (sync_lines)
    );

    boot_reset_timer #(
        .RESET_CYCLES(RESET_CYCLES)
    ) i_boot (
        .clk  (clk),
        .rst_n(rst_n),
        .busy (boot_busy)
    );

    arb_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_busy  (boot_busy),
        .client_req (client_req),
        .client_done(client_done),
        .grant_s_n  (sync_lines[2]),
        .as_s_n     (sync_lines[1]),
        .ack_s_n    (sync_lines[0]),
        .req_pull   (req_pull),
        .ack_pull   (ack_pull),
        .pass_en    (pass_en)
    );

    assign sysrst_pull  = boot_busy;
    assign client_grant = ack_pull;
    assign grant_out_n  = pass_en ? grant_in_n : 1'b1;
endmodule

// File: rtl/chain_bus_requester_chk.sv
module chain_bus_requester_chk #(
    parameter int RESET_CYCLES = 512
) (
    input logic clk,
    input logic rst_n,
    input logic client_done,
    input logic client_grant,
    input logic grant_in_n,
    input logic grant_out_n,
    input logic as_line_n,
    input logic ack_line_n,
    input logic req_pull,
    input logic ack_pull,
    input logic sysrst_pull
);
    localparam int HW = $clog2(RESET_CYCLES + 2);
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hi_cnt <= '0;
        else if (sysrst_pull && hi_cnt != HW'(RESET_CYCLES + 1))
                                     hi_cnt <= hi_cnt + 1'b1;
    end

    // R1
    boot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sysrst_pull) |-> hi_cnt == HW'(RESET_CYCLES));
    // R1
    boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sysrst_pull));
    // R2
    boot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_pull |-> (!req_pull && !ack_pull));
    // R3
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_pull && !ack_pull) |-> grant_out_n == grant_in_n);
    // R4
    grant_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pull || ack_pull) |-> grant_out_n);
    // R6
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_pull) |-> (!$past(grant_in_n, 3) && $past(as_line_n, 3) && $past(ack_line_n, 3)));
    // R9
    req_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_pull && ack_pull));
    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (client_grant && client_done) |=> !ack_pull);
endmodule

bind chain_bus_requester chain_bus_requester_chk #(.RESET_CYCLES(RESET_CYCLES)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .client_done (client_done),
    .client_grant(client_grant),
    .grant_in_n  (grant_in_n),
    .grant_out_n (grant_out_n),
    .as_line_n   (as_line_n),
    .ack_line_n  (ack_line_n),
    .req_pull    (req_pull),
    .ack_pull    (ack_pull),
    .sysrst_pull (sysrst_pull)
);

// File: tb/test_chain_bus_requester.sv
module test_chain_bus_requester;
    localparam int CLK_PERIOD   = 10;
    localparam int RESET_CYCLES = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic client_req = 1'b0, client_done = 1'b0;
    logic grant_in_n = 1'b1, as_n = 1'b1, other_ack_n = 1'b1;
    logic client_grant, grant_out_n, req_pull, ack_pull, sysrst_pull;
    logic ack_line_n;

    int n_checks = 0;
    int n_fail   = 0;

    assign ack_line_n = other_ack_n & ~ack_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_bus_requester #(.RESET_CYCLES(RESET_CYCLES)) i_chain_bus_requester (
        .clk(clk), .rst_n(rst_n),
        .client_req(client_req), .client_done(client_done), .client_grant(client_grant),
        .grant_in_n(grant_in_n), .grant_out_n(grant_out_n),
        .as_line_n(as_n), .ack_line_n(ack_line_n),
        .req_pull(req_pull), .ack_pull(ack_pull), .sysrst_pull(sysrst_pull)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int boot_len;
        // reset state
        repeat (3) @(negedge clk);
        check("R1 reset sysrst", int'(sysrst_pull), 1);
        check("R2 reset req", int'(req_pull), 0);
        check("R10 reset grant", int'(client_grant), 0);
        check("R3 reset pass", int'(grant_out_n), 1);

        // request held across the whole boot pulse
        client_req = 1'b1;
        rst_n = 1'b1;
        boot_len = 0;
        while (sysrst_pull && boot_len < RESET_CYCLES + 10) begin
            check("R2 boot req", int'(req_pull), 0);
            check("R2 boot ack", int'(ack_pull), 0);
            if (boot_len % 50 == 0 && boot_len < 450) begin
                grant_in_n = 1'b0; #1;
                check("R3 boot pass low", int'(grant_out_n), 0);
                grant_in_n = 1'b1; #1;
                check("R3 boot pass high", int'(grant_out_n), 1);
            end
            boot_len++;
            @(negedge clk);
        end
        check("R1 boot length", boot_len, RESET_CYCLES);
        check("R2 req at pulse end", int'(req_pull), 0);
        @(negedge clk);
        check("R2 req one edge later", int'(req_pull), 0);
        @(negedge clk);
        check("R2 req two edges later", int'(req_pull), 1);
        repeat (4) @(negedge clk);
        check("R1 sysrst stays low", int'(sysrst_pull), 0);

        // unbounded wait for grant
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            check("R7 req held", int'(req_pull), 1);
            check("R7 no ack", int'(ack_pull), 0);
            check("R4 grant blocked", int'(grant_out_n), 1);
        end
        grant_in_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R6 ack latency", int'(ack_pull), (k >= 4) ? 1 : 0);
            check("R9 req vs ack", int'(req_pull), (k >= 4) ? 0 : 1);
        end
        client_done = 1'b1; client_req = 1'b0; grant_in_n = 1'b1;
        @(negedge clk);
        check("R11 ack released", int'(ack_pull), 0);
        check("R11 grant released", int'(client_grant), 0);
        client_done = 1'b0;
        repeat (3) @(negedge clk);

        // previous owner still holds acknowledge
        other_ack_n = 1'b0;
        client_req = 1'b1;
        @(negedge clk);
        client_req = 1'b0;
        grant_in_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R8 ack held off", int'(ack_pull), 0);
        end
        other_ack_n = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check("R8 ack after release", int'(ack_pull), (k >= 3) ? 1 : 0);
        end
        client_done = 1'b1; grant_in_n = 1'b1;
        @(negedge clk);
        client_done = 1'b0;
        check("R11 ack released 2", int'(ack_pull), 0);
        repeat (3) @(negedge clk);

        // sweep: grant delay d, strobe busy b
        for (int d = 0; d < 6; d++) begin
            for (int b = 0; b < 4; b++) begin
                int exp_lat;
                exp_lat = (b + 3 > 4) ? b + 3 : 4;
                client_req = 1'b1;
                as_n = (b == 0);
                @(negedge clk);
                client_req = 1'b0;
                check("R5 req rise", int'(req_pull), 1);
                for (int w = 0; w < d; w++) begin
                    @(negedge clk);
                    check("R4 blocked while waiting", int'(grant_out_n), 1);
                    check("R7 ack low while waiting", int'(ack_pull), 0);
                end
                grant_in_n = 1'b0;
                for (int k = 1; k <= exp_lat; k++) begin
                    @(negedge clk);
                    check("R8 sweep ack edge", int'(ack_pull), (k >= exp_lat) ? 1 : 0);
                    check("R10 grant tracks ack", int'(client_grant), int'(ack_pull));
                    if (k == b) as_n = 1'b1;
                end
                client_done = 1'b1; grant_in_n = 1'b1;
                @(negedge clk);
                client_done = 1'b0;
                check("R11 sweep release", int'(ack_pull), 0);
                check("R11 sweep no req", int'(req_pull), 0);
                grant_in_n = 1'b0; #1;
                check("R3 pass after release low", int'(grant_out_n), 0);
                grant_in_n = 1'b1; #1;
                check("R3 pass after release high", int'(grant_out_n), 1);
                repeat (3) @(negedge clk);
            end
        end

        finish_run();
    end
endmodule